// File: doc/BRIEF.md
# CAN Interrupt Pending Aggregator

This block gathers every interrupt source of a CAN controller into one registered interrupt line for the host. The protocol engine sends single-cycle strobes for three events: a good reception, a good transmission, and a frame that ended in error, which comes with a 3-bit error type. The message handler sends a completion strobe for one of 128 message objects. That strobe carries the object index and a direction flag, and the object's own receive and transmit interrupt enables come in as two 128-bit vectors.

The block holds one pending bit per message object. It also keeps a small status register with receive-OK and transmit-OK flags, a last-error-code field and a status-pending flag. A read port returns any of four 32-bit pending words, a summary word with one bit per 32-object bank, or the status word. A status read is destructive: it clears both OK flags and the status-pending flag, and it parks the error code at 7. Software retires an object's pending bit with a clear strobe that carries the object index.

Top module: `can_irq_agg`

## Requirements
- R1: After reset all pending bits are 0, the OK flags and status-pending are 0, the error code is 7, and irq and rd_data are 0.
- R2: An obj_evt strobe sets pending bit obj_idx only when the matching enable is 1 (obj_txie[obj_idx] if obj_is_tx=1, obj_rxie[obj_idx] if obj_is_tx=0). Object index i (0-based) appears in pending word i/32 at bit i%32. Without the matching enable the pending bits stay unchanged.
- R3: A clr_stb clears pending bit clr_idx. If an enabled set for the same index comes in the same cycle, the bit ends up 1.
- R4: Summary bit g (read address 4) is 1 exactly when pending word g is nonzero.
- R5: Status word (read address 5) layout: bits 2:0 error code, bit 3 transmit-OK, bit 4 receive-OK, bit 5 status-pending, the rest 0. st_tx_ok and st_rx_ok set their flag and load code 0. st_err loads st_err_code, and it takes precedence over a success in the same cycle.
- R6: A read of address 5 returns the current status word. After it, the OK flags are 0 and the code is 7, except where a status event in the same cycle sets them.
- R7: Any status event sets status-pending. A status read clears it, and an event in the same cycle as the read wins.
- R8: irq equals, one cycle later, the OR of (stat_ie AND status-pending) and every object pending bit.
- R9: When rd_en is 1, rd_data loads the addressed word on the next edge (addresses 0 to 3 are pending words, 4 is the summary, 5 is status, 6 and 7 return 0). When rd_en is 0, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_rx_ok | input | 1 | Good reception strobe |
| st_tx_ok | input | 1 | Good transmission strobe |
| st_err | input | 1 | Errored frame strobe |
| st_err_code | input | 3 | Error type sent with st_err |
| stat_ie | input | 1 | Status interrupt enable |
| obj_evt | input | 1 | Message object completion strobe |
| obj_idx | input | 7 | Completing object, 0-based |
| obj_is_tx | input | 1 | 1 for a transmit completion, 0 for a receive completion |
| obj_rxie | input | 128 | Per-object receive interrupt enables |
| obj_txie | input | 128 | Per-object transmit interrupt enables |
| clr_stb | input | 1 | Pending clear strobe |
| clr_idx | input | 7 | Object whose pending bit is cleared |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register select |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt line |

## Verification
Two pairs of operations can collide in one cycle. A set and a clear can hit the same object, and a destructive status read can meet a new status event. Directed steps force both collisions and check fixed literal values: the pending bit stays set, the read returns the old status word, and the next read shows the new event intact. Random traffic then restricts object indices to a few per bank, which makes these collisions frequent. Every irq and rd_data value is compared against a bench-side model built from the requirements.

// File: rtl/can_irq_agg.sv
module can_irq_agg #(
  parameter int NOBJ = 128,
  parameter int W    = 32,
  parameter int IDXW = $clog2(NOBJ),
  parameter int NGRP = NOBJ / W,
  parameter int RAW  = $clog2(NGRP + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_rx_ok,
  input  logic            st_tx_ok,
  input  logic            st_err,
  input  logic [2:0]      st_err_code,
  input  logic            stat_ie,
  input  logic            obj_evt,
  input  logic [IDXW-1:0] obj_idx,
  input  logic            obj_is_tx,
  input  logic [NOBJ-1:0] obj_rxie,
  input  logic [NOBJ-1:0] obj_txie,
  input  logic            clr_stb,
  input  logic [IDXW-1:0] clr_idx,
  input  logic            rd_en,
  input  logic [RAW-1:0]  rd_addr,
  output logic [W-1:0]    rd_data,
  output logic            irq
);

  logic [NOBJ-1:0] pend, pend_nxt;
  logic [NGRP-1:0] summ;
  logic            rx_ok, tx_ok, stat_pend;
  logic [2:0]      lec;
  logic [W-1:0]    rd_mux;

  wire set_hit = obj_evt & (obj_is_tx ? obj_txie[obj_idx] : obj_rxie[obj_idx]);
  wire st_rd   = rd_en & (rd_addr == RAW'(NGRP + 1));
  wire st_any  = st_rx_ok | st_tx_ok | st_err;

  always_comb begin
    pend_nxt = pend;
    if (clr_stb) pend_nxt[clr_idx] = 1'b0;
    if (set_hit) pend_nxt[obj_idx] = 1'b1;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_summ
    assign summ[g] = |pend[g*W +: W];
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++)
      if (rd_addr == RAW'(g)) rd_mux = pend[g*W +: W];
    if (rd_addr == RAW'(NGRP))     rd_mux = W'(summ);
    if (rd_addr == RAW'(NGRP + 1)) rd_mux = W'({stat_pend, rx_ok, tx_ok, lec});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      rx_ok     <= 1'b0;
      tx_ok     <= 1'b0;
      stat_pend <= 1'b0;
      lec       <= 3'd7;
      rd_data   <= '0;
      irq       <= 1'b0;
    end else begin
      pend      <= pend_nxt;
      rx_ok     <= st_rx_ok | (rx_ok & ~st_rd);
      tx_ok     <= st_tx_ok | (tx_ok & ~st_rd);
      stat_pend <= st_any | (stat_pend & ~st_rd);
      if (st_err)                   lec <= st_err_code;
      else if (st_rx_ok | st_tx_ok) lec <= 3'd0;
      else if (st_rd)               lec <= 3'd7;
      if (rd_en) rd_data <= rd_mux;
      irq <= (stat_ie & stat_pend) | (|pend);
    end
  end

endmodule

// File: rtl/can_irq_agg_chk.sv
module can_irq_agg_chk #(
  parameter int NOBJ = 128,
  parameter int W    = 32,
  parameter int IDXW = 7,
  parameter int RAW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_rx_ok,
  input logic            st_tx_ok,
  input logic            st_err,
  input logic [2:0]      st_err_code,
  input logic            obj_evt,
  input logic            set_hit,
  input logic [IDXW-1:0] obj_idx,
  input logic            clr_stb,
  input logic [IDXW-1:0] clr_idx,
  input logic            rd_en,
  input logic [RAW-1:0]  rd_addr,
  input logic [NOBJ-1:0] pend,
  input logic [2:0]      lec,
  input logic            rx_ok,
  input logic            tx_ok,
  input logic [W-1:0]    rd_data,
  input logic            irq
);

  a_r2_no_enable_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_evt && !set_hit && !clr_stb) |=> $stable(pend));

  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && clr_stb && clr_idx == obj_idx) |=> pend[$past(obj_idx)]);

  a_r5_err_loads_code: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |=> lec == $past(st_err_code));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == RAW'(5) && !st_rx_ok && !st_tx_ok && !st_err)
      |=> (lec == 3'd7 && !rx_ok && !tx_ok));

  a_r8_pending_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> irq);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind can_irq_agg can_irq_agg_chk #(.NOBJ(NOBJ), .W(W), .IDXW(IDXW), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_rx_ok(st_rx_ok), .st_tx_ok(st_tx_ok),
  .st_err(st_err), .st_err_code(st_err_code), .obj_evt(obj_evt),
  .set_hit(set_hit), .obj_idx(obj_idx), .clr_stb(clr_stb), .clr_idx(clr_idx),
  .rd_en(rd_en), .rd_addr(rd_addr), .pend(pend), .lec(lec), .rx_ok(rx_ok),
  .tx_ok(tx_ok), .rd_data(rd_data), .irq(irq)
);

// File: tb/can_irq_agg_tb.sv
module can_irq_agg_tb;
  localparam int CLKP = 20;

  logic         clk = 0, rst_n = 0;
  logic         st_rx_ok, st_tx_ok, st_err, stat_ie, obj_evt, obj_is_tx, clr_stb, rd_en;
  logic [2:0]   st_err_code, rd_addr;
  logic [6:0]   obj_idx, clr_idx;
  logic [127:0] obj_rxie, obj_txie;
  logic [31:0]  rd_data;
  logic         irq;

  can_irq_agg u_dut (.*);

  always #(CLKP/2) clk = ~clk;

  int vecs = 0, errs = 0;
  bit chk_on = 0, done = 0;

  logic [127:0] mp;
  logic         mrx, mtx, msp, mirq;
  logic [2:0]   mlec;
  logic [31:0]  mrd;

  function automatic logic [31:0] mword(logic [2:0] a);
    if (a < 4) return mp[a*32 +: 32];
    if (a == 4) return {28'b0, |mp[127:96], |mp[95:64], |mp[63:32], |mp[31:0]};
    if (a == 5) return {26'b0, msp, mrx, mtx, mlec};
    return 32'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp <= '0; mrx <= 0; mtx <= 0; msp <= 0; mlec <= 3'd7; mrd <= '0; mirq <= 0;
    end else begin
      automatic logic [127:0] n = mp;
      automatic bit rd5 = rd_en && rd_addr == 3'd5;
      if (clr_stb) n[clr_idx] = 1'b0;
      if (obj_evt && (obj_is_tx ? obj_txie[obj_idx] : obj_rxie[obj_idx])) n[obj_idx] = 1'b1;
      mp   <= n;
      mrx  <= st_rx_ok | (mrx & !rd5);
      mtx  <= st_tx_ok | (mtx & !rd5);
      msp  <= (st_rx_ok | st_tx_ok | st_err) | (msp & !rd5);
      mlec <= st_err ? st_err_code : (st_rx_ok | st_tx_ok) ? 3'd0 : rd5 ? 3'd7 : mlec;
      if (rd_en) mrd <= mword(rd_addr);
      mirq <= (stat_ie & msp) | (|mp);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) begin
    check("R8 irq", {31'b0, irq}, {31'b0, mirq});
    check("R9 rd_data", rd_data, mrd);
  end

  task automatic idle();
    st_rx_ok = 0; st_tx_ok = 0; st_err = 0; st_err_code = 0;
    obj_evt = 0; obj_idx = 0; obj_is_tx = 0; clr_stb = 0; clr_idx = 0;
    rd_en = 0; rd_addr = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rd(logic [2:0] a);
    rd_en = 1; rd_addr = a; cyc();
  endtask

  initial begin
    #(CLKP * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5417));
    idle(); stat_ie = 1; obj_rxie = '0; obj_txie = '1;
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    check("R1 irq after reset", {31'b0, irq}, 0);
    check("R1 rd_data after reset", rd_data, 0);
    rd(3'd5); check("R1 status reset word", rd_data, 32'h7);
    rd(3'd0); check("R1 pending word0 reset", rd_data, 0);

    obj_evt = 1; obj_idx = 40; obj_is_tx = 0; cyc();
    rd(3'd1); check("R2 receive without enable ignored", rd_data, 0);
    obj_evt = 1; obj_idx = 40; obj_is_tx = 1; cyc();
    rd(3'd1); check("R2 transmit sets word1 bit8", rd_data, 32'h100);
    check("R8 irq with pending", {31'b0, irq}, 1);
    rd(3'd4); check("R4 summary bank1", rd_data, 32'h2);

    obj_evt = 1; obj_idx = 40; obj_is_tx = 1; clr_stb = 1; clr_idx = 40; cyc();
    rd(3'd1); check("R3 set wins over clear", rd_data, 32'h100);
    clr_stb = 1; clr_idx = 40; cyc();
    rd(3'd1); check("R3 clear alone", rd_data, 0);
    rd(3'd4); check("R4 summary empty", rd_data, 0);

    rd(3'd5);
    st_rx_ok = 1; cyc();
    rd_en = 1; rd_addr = 5; st_tx_ok = 1; cyc();
    check("R6 read returns old status", rd_data, 32'h30);
    rd(3'd5); check("R7 event beats read", rd_data, 32'h28);
    rd(3'd5); check("R6 read clears status", rd_data, 32'h7);
    st_err = 1; st_err_code = 3; st_rx_ok = 1; cyc();
    rd(3'd5); check("R5 error code beats success", rd_data, 32'h33);
    rd(3'd6); check("R9 unused address", rd_data, 0);

    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        obj_rxie = {$urandom, $urandom, $urandom, $urandom};
        obj_txie = {$urandom, $urandom, $urandom, $urandom};
        stat_ie  = $urandom % 2;
      end
      st_rx_ok = ($urandom % 12) == 0;
      st_tx_ok = ($urandom % 12) == 0;
      st_err   = ($urandom % 10) == 0;
      st_err_code = 3'($urandom);
      obj_evt  = ($urandom % 3) == 0;
      obj_idx  = 7'(($urandom % 4) * 32 + ($urandom % 6));
      obj_is_tx = $urandom % 2;
      clr_stb  = ($urandom % 3) == 0;
      clr_idx  = ($urandom % 3 == 0) ? obj_idx : 7'(($urandom % 4) * 32 + ($urandom % 6));
      rd_en    = ($urandom % 2) == 0;
      rd_addr  = 3'($urandom);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule